// File: doc/BRIEF.md
# Interrupt Entry Bus Watcher

This block sits beside an 8-bit microprocessor and watches its bus. It reports that the processor has started an interrupt entry, and it does so several bus cycles before the vector is read. The clue is the cycle after an opcode fetch. In ordinary execution that cycle reads the next sequential address. When the processor takes an interrupt, it reads the same address again, because the un-incremented program counter is about to be saved. The block compares address bit 0 with its value from the previous valid bus cycle. If the previous cycle was an opcode fetch and the bit has not changed, an interrupt entry has begun.

Once the entry is detected, the block holds an acknowledge until the high byte of the vector has been read. While the acknowledge is held it flags every write cycle as a stack push. When such a push falls in the stack page, it drives a select that sends the write to a small private scratch RAM. During the same period it flags reads from the vector area at the top of memory. A second, independent indicator fires on the third write in a row. It also catches entries that the main detector misses, such as a software break, which reads the next address instead of repeating the current one.

A cycle-enable input marks which clock cycles carry a real bus transaction. All comparison history and the write-run count advance only on those cycles.

Top module: `irq_entry_watch`

## Requirements
- R1: On an enabled read cycle, `early_ack_o` is high in that same cycle if the previous enabled cycle had `opfetch_i` high and `addr_i[0]` equals its value in that previous cycle.
- R2: An enabled read after an opcode fetch whose `addr_i[0]` differs from the fetch (sequential read, as in a software break) does not raise `early_ack_o`.
- R3: After detection, `early_ack_o` stays high on every enabled cycle up to and including the enabled read of an address with bit 0 = 1 in 0xFFFA–0xFFFF. It is low from the next cycle on.
- R4: `push_win_o` is high on an enabled write cycle while the acknowledge is held (a cycle after the detecting cycle).
- R5: `scratch_sel_o` is high exactly when `push_win_o` is high and `addr_i[15:8]` equals 0x01. A held-acknowledge write outside that page gives `push_win_o` = 1 and `scratch_sel_o` = 0.
- R6: `vec_fetch_o` is high on an enabled read of 0xFFFA–0xFFFF while the acknowledge is held. It is low for such reads when no acknowledge is held.
- R7: `triple_wr_o` is high on the third consecutive enabled write (`rd_wr_i` = 0). It is not high on the fourth, and an enabled read restarts the count.
- R8: When `cyc_en_i` is low, all outputs are low, and that cycle changes neither the comparison history nor the write-run count.
- R9: Reset (`rst_ni` low) clears the history, the held acknowledge and the write-run count. After reset, a read repeating a pre-reset fetch address raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en_i | input | 1 | High on clock cycles that carry a valid bus transaction |
| opfetch_i | input | 1 | Opcode-fetch strobe of the processor |
| addr_i | input | 16 | Processor address bus |
| rd_wr_i | input | 1 | 1 = read cycle, 0 = write cycle |
| early_ack_o | output | 1 | Interrupt entry detected and not yet finished |
| push_win_o | output | 1 | Current write is an interrupt-entry stack push |
| scratch_sel_o | output | 1 | Steer current push to private scratch RAM |
| vec_fetch_o | output | 1 | Current read is an interrupt vector byte |
| triple_wr_o | output | 1 | Third write in a row (fallback entry indicator) |

## Verification
During a genuine interrupt entry, the third stack push is both a push-window cycle and the third consecutive write. The cycle therefore raises `push_win_o`, `scratch_sel_o` and `triple_wr_o` together. The bench drives a full entry sequence: a fetch, a repeated read, three writes into the stack page, and two vector reads. It expects all three flags in that one cycle, and only the fallback flag on the same pushes after a software break. Stalled cycles with misleading strobe and address values are placed inside both sequences. They show that neither function picks up state from a non-enabled cycle.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  // Default widths and constants shared by the watcher modules.
  localparam int unsigned IRQW_ADDR_W     = 16;
  localparam int unsigned IRQW_RUN_LEN    = 3;
  localparam int unsigned IRQW_RST_STAGES = 2;

  // One enabled bus cycle as remembered for the next comparison.
  typedef struct packed {
    logic fetch;
    logic a0;
  } bus_hist_t;
endpackage

// File: rtl/irqw_rst_sync.sv
module irqw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/irqw_history.sv
module irqw_history
  import irqw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      fetch_i,
  input  logic      a0_i,
  output bus_hist_t hist_o
);
  bus_hist_t hist_q;
  bus_hist_t hist_d;

  always_comb begin
    hist_d = hist_q;
    if (en_i) begin
      hist_d.fetch = fetch_i;
      hist_d.a0    = a0_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/irqw_wr_run.sv
module irqw_wr_run #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic is_wr_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] SAT  = CW'(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (!is_wr_i)         cnt_d = '0;
      else if (cnt_q < SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hit_o = en_i && is_wr_i && (cnt_q == LAST);
endmodule

// File: rtl/irqw_entry_track.sv
module irqw_entry_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic detect_i,
  input  logic done_i,
  output logic held_o
);
  logic held_q;
  logic held_d;

  always_comb begin
    held_d = held_q;
    if (en_i) begin
      if (held_q && done_i) held_d = 1'b0;
      else if (detect_i)    held_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= held_d;
  end

  assign held_o = held_q;
endmodule

// File: rtl/irq_entry_watch.sv
module irq_entry_watch
  import irqw_pkg::*;
#(
  parameter int unsigned ADDR_W     = IRQW_ADDR_W,
  parameter int unsigned RUN_LEN    = IRQW_RUN_LEN,
  parameter int unsigned RST_STAGES = IRQW_RST_STAGES,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              opfetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_wr_i,
  output logic              early_ack_o,
  output logic              push_win_o,
  output logic              scratch_sel_o,
  output logic              vec_fetch_o,
  output logic              triple_wr_o
);
  localparam logic [ADDR_W-1:0] VEC_LO = {ADDR_W{1'b1}} - ADDR_W'(5);

  logic      rst_n;
  bus_hist_t hist;
  logic      held;
  logic      detect;
  logic      in_vec;
  logic      vec_done;
  logic      run_hit;

  irqw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  irqw_history u_hist (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(cyc_en_i),
    .fetch_i(opfetch_i), .a0_i(addr_i[0]), .hist_o(hist)
  );

  // Repeated fetch address after an opcode fetch marks interrupt entry.
  assign detect   = cyc_en_i && rd_wr_i && hist.fetch && (addr_i[0] == hist.a0);
  assign in_vec   = (addr_i >= VEC_LO);
  assign vec_done = rd_wr_i && in_vec && addr_i[0];

  irqw_entry_track u_track (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(cyc_en_i),
    .detect_i(detect), .done_i(vec_done), .held_o(held)
  );

  irqw_wr_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(cyc_en_i),
    .is_wr_i(!rd_wr_i), .hit_o(run_hit)
  );

  always_comb begin
    early_ack_o   = cyc_en_i && (detect || held);
    push_win_o    = cyc_en_i && held && !rd_wr_i;
    scratch_sel_o = push_win_o && (addr_i[ADDR_W-1 -: 8] == STACK_PAGE);
    vec_fetch_o   = cyc_en_i && held && rd_wr_i && in_vec;
    triple_wr_o   = run_hit;
  end
endmodule

// File: rtl/irqw_checker.sv
module irqw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_en_i,
  input logic [15:0] addr_i,
  input logic        rd_wr_i,
  input logic        early_ack_o,
  input logic        push_win_o,
  input logic        scratch_sel_o,
  input logic        vec_fetch_o,
  input logic        triple_wr_o
);
  a_r4_push_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_win_o |-> (!rd_wr_i && early_ack_o));

  a_r5_sel_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scratch_sel_o |-> (push_win_o && addr_i[15:8] == 8'h01));

  a_r6_vec_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |-> (early_ack_o && rd_wr_i && addr_i >= 16'hFFFA));

  a_r3_clear_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_o && addr_i[0]) |=> !early_ack_o);

  a_r7_run_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triple_wr_o |-> (!rd_wr_i && cyc_en_i));

  a_r7_not_twice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triple_wr_o && cyc_en_i) |=> !(triple_wr_o && $past(cyc_en_i) && cyc_en_i && !rd_wr_i && $past(!rd_wr_i)));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |-> !(early_ack_o || push_win_o || scratch_sel_o || vec_fetch_o || triple_wr_o));
endmodule

bind irq_entry_watch irqw_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i), .addr_i(addr_i),
  .rd_wr_i(rd_wr_i), .early_ack_o(early_ack_o), .push_win_o(push_win_o),
  .scratch_sel_o(scratch_sel_o), .vec_fetch_o(vec_fetch_o), .triple_wr_o(triple_wr_o)
);

// File: tb/irq_entry_watch_tb_top.sv
module irq_entry_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        sync;
  logic [15:0] addr;
  logic        rd;
  logic        ack, push, sel, vec, tri3;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  always #5 clk = ~clk;

  irq_entry_watch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(en), .opfetch_i(sync),
    .addr_i(addr), .rd_wr_i(rd), .early_ack_o(ack), .push_win_o(push),
    .scratch_sel_o(sel), .vec_fetch_o(vec), .triple_wr_o(tri3)
  );

  // Expected bit order: {ack, push, sel, vec, triple}
  task automatic cyc(input logic e, input logic s, input logic [15:0] a,
                     input logic r, input logic [4:0] x, input string t);
    @(posedge clk); #1;
    en = e; sync = s; addr = a; rd = r;
    q.push_back('{exp: x, tag: t});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      en = 1'b0; sync = 1'b0; rd = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      logic [4:0] got;
      it  = q.pop_front();
      got = {ack, push, sel, vec, tri3};
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sync = 1'b0; addr = 16'h0000; rd = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    // R9 reset state: plain enabled read raises nothing
    cyc(1, 0, 16'h2000, 1, 5'b00000, "R9 reset state");

    // Full interrupt entry; third push coincides with fallback (R1 R4 R5 R6 R7 R3)
    cyc(1, 1, 16'h8000, 1, 5'b00000, "R1 fetch");
    cyc(1, 0, 16'h8000, 1, 5'b10000, "R1 repeat detect");
    cyc(1, 0, 16'h01FF, 0, 5'b11100, "R5 push hi");
    cyc(1, 0, 16'h01FE, 0, 5'b11100, "R4 push lo");
    cyc(1, 0, 16'h01FD, 0, 5'b11101, "R7 push status + triple");
    cyc(1, 0, 16'hFFFE, 1, 5'b10010, "R6 vector low");
    cyc(1, 0, 16'hFFFF, 1, 5'b10010, "R3 vector high");
    cyc(1, 1, 16'h9000, 1, 5'b00000, "R3 cleared");
    cyc(1, 0, 16'h9001, 1, 5'b00000, "R2 sequential read");

    // Software break: sequential read, only the fallback fires (R2 R6 R7)
    cyc(1, 1, 16'h8003, 1, 5'b00000, "R2 brk fetch");
    cyc(1, 0, 16'h8004, 1, 5'b00000, "R2 brk no detect");
    cyc(1, 0, 16'h01FF, 0, 5'b00000, "R5 no sel w/o ack");
    cyc(1, 0, 16'h01FE, 0, 5'b00000, "R7 second write");
    cyc(1, 0, 16'h01FD, 0, 5'b00001, "R7 brk triple");
    cyc(1, 0, 16'hFFFE, 1, 5'b00000, "R6 no vec w/o ack");
    cyc(1, 0, 16'hFFFF, 1, 5'b00000, "R6 no vec w/o ack hi");

    // Stalls inside detection and hold (R8 R3 R5)
    cyc(1, 1, 16'h8005, 1, 5'b00000, "R8 fetch");
    cyc(0, 1, 16'h8006, 1, 5'b00000, "R8 stall quiet");
    cyc(0, 0, 16'h0102, 0, 5'b00000, "R8 stall write quiet");
    cyc(1, 0, 16'h8005, 1, 5'b10000, "R8 history kept");
    cyc(0, 0, 16'h0200, 0, 5'b00000, "R8 stall in hold");
    cyc(1, 0, 16'h0210, 0, 5'b11000, "R5 push off page");
    cyc(1, 0, 16'hFFFA, 1, 5'b10010, "R3 even vector keeps ack");
    cyc(1, 0, 16'hFFFB, 1, 5'b10010, "R6 vector high");
    cyc(1, 0, 16'h1234, 1, 5'b00000, "R3 cleared after FFFB");

    // Write run with stalls and breaks (R7 R8)
    cyc(1, 0, 16'h3000, 0, 5'b00000, "R7 w1");
    cyc(0, 0, 16'h3001, 1, 5'b00000, "R8 stalled read no reset");
    cyc(1, 0, 16'h3002, 0, 5'b00000, "R7 w2");
    cyc(1, 0, 16'h3003, 0, 5'b00001, "R7 w3 across stall");
    cyc(1, 0, 16'h3004, 0, 5'b00000, "R7 fourth quiet");
    cyc(1, 0, 16'h3005, 1, 5'b00000, "R7 read");
    cyc(1, 0, 16'h3006, 0, 5'b00000, "R7 w1 again");
    cyc(1, 0, 16'h3007, 0, 5'b00000, "R7 w2 again");
    cyc(1, 0, 16'h3008, 1, 5'b00000, "R7 break by read");
    cyc(1, 0, 16'h3009, 0, 5'b00000, "R7 restart w1");

    // Reset mid-sequence clears history (R9)
    cyc(1, 1, 16'h8010, 1, 5'b00000, "R9 fetch before reset");
    idle(1);
    #1 rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    idle(4);
    cyc(1, 0, 16'h8010, 1, 5'b00000, "R9 history cleared");
    cyc(1, 0, 16'h4000, 0, 5'b00000, "R9 run w1");
    cyc(1, 0, 16'h4001, 0, 5'b00000, "R9 run w2");
    cyc(1, 0, 16'h4002, 0, 5'b00001, "R9 run w3");
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule